// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block runs the descriptor side of a multi-channel display fetch engine. Each channel owns a small set of registers: a next-descriptor pointer, a frame source address, a frame identifier, a command word, and a one-shot branch register. When a frame start pulse arrives, a single sequencer visits the channels in ascending order. For each enabled channel, it reads a four-word descriptor from memory through a simple read port that has one request outstanding at a time. It then latches the four words into that channel's registers.

The descriptor address comes from one of two places. If software has armed the branch register, the address comes from there, and the branch request is dropped once it has been used. Otherwise the address is the stored next pointer. An address that falls outside the valid memory window is not fetched. A channel left with a zero or out-of-window source address reports a bus error tagged with its channel number. A branch taken with its interrupt enable set produces a branch event. The command word of any channel selected on the register port is also decoded into its length and flag fields, so a neighbouring block can use them.

Top module: `ldf_fetch`

## Requirements
- R1: After reset, every channel field reads zero, `busy` is low and no read request is issued.
- R2: A write to the next-pointer field (`reg_sel`=0) stores the data ANDed with 0xFFFFFFF0. A write to the branch field (`reg_sel`=4) stores the data ANDed with 0xFFFFFFF3. Writes to source (1), ID (2) and command (3) have no effect. A `reg_ch` at or beyond the channel count reads zero and ignores writes.
- R3: On `frame_start`, channels are handled one at a time in ascending order, and each channel's source field is cleared first. A channel whose `ch_en` bit is low issues no read and raises no event, and its next, ID, command and branch fields keep their values.
- R4: For an enabled channel, if branch bit 0 (request) is set, the descriptor address is the branch value with bits 3:0 cleared, and bit 0 is then cleared by the hardware. Otherwise the stored next pointer is used.
- R5: When a branch is taken and branch bit 1 (interrupt enable) is set, `ev_branch` pulses for one cycle with `ev_branch_ch` equal to that channel. No pulse occurs when bit 1 is clear or bit 0 is clear.
- R6: A fetch reads addresses A, A+4, A+8 and A+12, and stores them as next pointer, source address, frame ID and command word, in that order.
- R7: A descriptor address A is fetched only when WIN_BASE <= A and A+16 <= WIN_BASE+WIN_SIZE. Otherwise no read is issued and the source field stays zero.
- R8: An enabled channel whose source field is zero, below WIN_BASE or above WIN_BASE+WIN_SIZE after its load step pulses `ev_buserr` once, with `ev_buserr_ch` set to that channel.
- R9: `rd_req` is a one-cycle pulse, and no new request is issued until `rd_valid` has returned the previous word.
- R10: For the channel selected by `reg_ch`, `sel_len_words` equals command bits 20:2, `sel_eof_ie` equals bit 21, `sel_sof_ie` equals bit 22 and `sel_pal` equals bit 26.
- R11: `busy` is high from the cycle after an accepted `frame_start` until `frame_done` pulses for one cycle after the last channel. A `frame_start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that begins a descriptor pass |
| ch_en | input | NUM_CH | Per-channel enable |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 32 | Read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | CH_W | Register channel select |
| reg_sel | input | 3 | Field select: 0 next, 1 source, 2 ID, 3 command, 4 branch |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected field value |
| sel_len_words | output | 19 | Command bits 20:2 of selected channel |
| sel_eof_ie | output | 1 | Command bit 21 of selected channel |
| sel_sof_ie | output | 1 | Command bit 22 of selected channel |
| sel_pal | output | 1 | Command bit 26 of selected channel |
| busy | output | 1 | Pass in progress |
| frame_done | output | 1 | One-cycle pulse at end of pass |
| ev_branch | output | 1 | Branch event pulse |
| ev_branch_ch | output | CH_W | Channel of branch event |
| ev_buserr | output | 1 | Bus error pulse |
| ev_buserr_ch | output | CH_W | Channel of bus error |

## Verification
The bench builds the block with three channels and a 256-byte window at 0x1000. This lets every descriptor slot and both window edges be hit with a tiny memory image. It sweeps all eight enable masks against eight rotated per-channel scenarios: plain link, branch with and without interrupt, interrupt enable without request, descriptor outside the window on either side, zero source, out-of-window source, and a descriptor in the last legal slot. The memory responder varies its latency by address, so the one-outstanding rule is checked under uneven response timing. A second `frame_start` during a pass shows that the extra pulse is ignored.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [2:0] FLD_NEXT   = 3'd0;
  localparam logic [2:0] FLD_SRC    = 3'd1;
  localparam logic [2:0] FLD_ID     = 3'd2;
  localparam logic [2:0] FLD_CMD    = 3'd3;
  localparam logic [2:0] FLD_BRANCH = 3'd4;

  localparam logic [WORD_W-1:0] NEXT_WMASK   = 32'hFFFF_FFF0;
  localparam logic [WORD_W-1:0] BRANCH_WMASK = 32'hFFFF_FFF3;

  localparam int unsigned BR_REQ_BIT = 0;
  localparam int unsigned BR_IE_BIT  = 1;

  localparam int unsigned CMD_EOF_BIT = 21;
  localparam int unsigned CMD_SOF_BIT = 22;
  localparam int unsigned CMD_PAL_BIT = 26;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd3,
    ST_CHK  = 3'd4,
    ST_FIN  = 3'd5
  } seq_e;
endpackage

// File: rtl/ldf_window.sv
module ldf_window #(
  parameter logic [31:0] BASE = 32'h0000_1000,
  parameter logic [31:0] SIZE = 32'h0000_0100,
  parameter int unsigned SPAN = 16
) (
  input  logic [31:0] addr,
  output logic        ok
);
  localparam logic [32:0] LO = {1'b0, BASE};
  localparam logic [32:0] HI = {1'b0, BASE} + {1'b0, SIZE} - 33'(SPAN);

  always_comb begin
    ok = ({1'b0, addr} >= LO) && ({1'b0, addr} <= HI);
  end
endmodule

// File: rtl/ldf_chan_regs.sv
module ldf_chan_regs
  import ldf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_next,
  input  logic              sw_wr_branch,
  input  logic [WORD_W-1:0] sw_data,
  input  logic              hw_clr_src,
  input  logic              hw_clr_bra,
  input  logic              hw_ld_en,
  input  logic [1:0]        hw_ld_idx,
  input  logic [WORD_W-1:0] hw_ld_data,
  output logic [WORD_W-1:0] next_o,
  output logic [WORD_W-1:0] src_o,
  output logic [WORD_W-1:0] id_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] branch_o
);
  logic [WORD_W-1:0] next_q, next_d;
  logic [WORD_W-1:0] src_q, src_d;
  logic [WORD_W-1:0] id_q, id_d;
  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic [WORD_W-1:0] br_q, br_d;
  logic              next_en, src_en, id_en, cmd_en, br_en;

  // Hardware loads take priority over a software write in the same cycle.
  always_comb begin
    next_d = next_q;
    src_d  = src_q;
    id_d   = id_q;
    cmd_d  = cmd_q;
    br_d   = br_q;
    if (sw_wr_next)   next_d = sw_data & NEXT_WMASK;
    if (sw_wr_branch) br_d   = sw_data & BRANCH_WMASK;
    if (hw_clr_bra)   br_d[BR_REQ_BIT] = 1'b0;
    if (hw_clr_src)   src_d  = '0;
    if (hw_ld_en) begin
      unique case (hw_ld_idx)
        2'd0:    next_d = hw_ld_data;
        2'd1:    src_d  = hw_ld_data;
        2'd2:    id_d   = hw_ld_data;
        default: cmd_d  = hw_ld_data;
      endcase
    end
    next_en = sw_wr_next || (hw_ld_en && hw_ld_idx == 2'd0);
    src_en  = hw_clr_src || (hw_ld_en && hw_ld_idx == 2'd1);
    id_en   = hw_ld_en && hw_ld_idx == 2'd2;
    cmd_en  = hw_ld_en && hw_ld_idx == 2'd3;
    br_en   = sw_wr_branch || hw_clr_bra;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      src_q  <= '0;
      id_q   <= '0;
      cmd_q  <= '0;
      br_q   <= '0;
    end else begin
      if (next_en) next_q <= next_d;
      if (src_en)  src_q  <= src_d;
      if (id_en)   id_q   <= id_d;
      if (cmd_en)  cmd_q  <= cmd_d;
      if (br_en)   br_q   <= br_d;
    end
  end

  assign next_o   = next_q;
  assign src_o    = src_q;
  assign id_o     = id_q;
  assign cmd_o    = cmd_q;
  assign branch_o = br_q;

  assert_bra_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr_bra |=> !branch_o[BR_REQ_BIT]);

  assert_src_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr_src && !hw_ld_en) |=> (src_o == '0));

  assert_next_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_next && !hw_ld_en) |=> (next_o[3:0] == 4'd0));

  assert_branch_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_branch && !hw_clr_bra) |=> (branch_o[3:2] == 2'd0));
endmodule

// File: rtl/ldf_seq.sv
module ldf_seq
  import ldf_pkg::*;
#(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CH_W     = 2,
  parameter logic [31:0] WIN_BASE = 32'h0000_1000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cur_en,
  input  logic [WORD_W-1:0] cur_branch,
  input  logic [WORD_W-1:0] cur_next,
  input  logic [WORD_W-1:0] cur_src,
  input  logic              rd_valid,
  output logic [CH_W-1:0]   cur_ch,
  output logic              clr_src,
  output logic              clr_bra,
  output logic              ld_en,
  output logic [1:0]        ld_idx,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  output logic              busy,
  output logic              frame_done,
  output logic              ev_branch,
  output logic [CH_W-1:0]   ev_branch_ch,
  output logic              ev_buserr,
  output logic [CH_W-1:0]   ev_buserr_ch
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
  localparam int unsigned     DESC_BYTES = 16;

  seq_e              state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [1:0]        word_q, word_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic              br_fire, be_fire, adv;
  logic              brev_q, beev_q;
  logic [CH_W-1:0]   brch_q, bech_q;
  logic [WORD_W-1:0] sel_addr;
  logic              desc_ok, src_ok;

  always_comb begin
    sel_addr = cur_branch[BR_REQ_BIT] ? {cur_branch[WORD_W-1:4], 4'd0} : cur_next;
  end

  ldf_window #(.BASE(WIN_BASE), .SIZE(WIN_SIZE), .SPAN(DESC_BYTES)) u_desc_win (
    .addr (sel_addr),
    .ok   (desc_ok)
  );

  ldf_window #(.BASE(WIN_BASE), .SIZE(WIN_SIZE), .SPAN(0)) u_src_win (
    .addr (cur_src),
    .ok   (src_ok)
  );

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    word_d  = word_q;
    base_d  = base_q;
    clr_src = 1'b0;
    clr_bra = 1'b0;
    ld_en   = 1'b0;
    rd_req  = 1'b0;
    br_fire = 1'b0;
    be_fire = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          ch_d    = '0;
          state_d = ST_SEL;
        end
      end
      ST_SEL: begin
        clr_src = 1'b1;
        if (!cur_en) begin
          adv = 1'b1;
        end else begin
          if (cur_branch[BR_REQ_BIT]) begin
            clr_bra = 1'b1;
            br_fire = cur_branch[BR_IE_BIT];
          end
          if (desc_ok) begin
            base_d  = sel_addr;
            word_d  = 2'd0;
            state_d = ST_REQ;
          end else begin
            state_d = ST_CHK;
          end
        end
      end
      ST_REQ: begin
        rd_req  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_valid) begin
          ld_en = 1'b1;
          if (word_q == 2'd3) begin
            state_d = ST_CHK;
          end else begin
            word_d  = word_q + 2'd1;
            state_d = ST_REQ;
          end
        end
      end
      ST_CHK: begin
        be_fire = (cur_src == '0) || !src_ok;
        adv     = 1'b1;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    if (adv) begin
      if (ch_q == LAST_CH) begin
        state_d = ST_FIN;
      end else begin
        ch_d    = ch_q + CH_W'(1);
        state_d = ST_SEL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      word_q  <= '0;
      base_q  <= '0;
      brev_q  <= 1'b0;
      brch_q  <= '0;
      beev_q  <= 1'b0;
      bech_q  <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      word_q  <= word_d;
      base_q  <= base_d;
      brev_q  <= br_fire;
      beev_q  <= be_fire;
      if (br_fire) brch_q <= ch_q;
      if (be_fire) bech_q <= ch_q;
    end
  end

  assign cur_ch       = ch_q;
  assign ld_idx       = word_q;
  assign rd_addr      = base_q + {28'd0, word_q, 2'b00};
  assign busy         = (state_q != ST_IDLE);
  assign frame_done   = (state_q == ST_FIN);
  assign ev_branch    = brev_q;
  assign ev_branch_ch = brch_q;
  assign ev_buserr    = beev_q;
  assign ev_buserr_ch = bech_q;

  assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_fetch_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (({1'b0, rd_addr} >= {1'b0, WIN_BASE}) &&
                ({1'b0, rd_addr} + 33'd4 <= {1'b0, WIN_BASE} + {1'b0, WIN_SIZE})));

  assert_buserr_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buserr |-> (ev_buserr_ch <= LAST_CH));

  assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  assert_start_accepted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_start) |=> busy);
endmodule

// File: rtl/ldf_fetch.sv
module ldf_fetch
  import ldf_pkg::*;
#(
  parameter int unsigned NUM_CH   = 3,
  parameter logic [31:0] WIN_BASE = 32'h0000_1000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_0100,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] ch_en,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  input  logic              reg_wr,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [18:0]       sel_len_words,
  output logic              sel_eof_ie,
  output logic              sel_sof_ie,
  output logic              sel_pal,
  output logic              busy,
  output logic              frame_done,
  output logic              ev_branch,
  output logic [CH_W-1:0]   ev_branch_ch,
  output logic              ev_buserr,
  output logic [CH_W-1:0]   ev_buserr_ch
);
  logic [WORD_W-1:0] next_a   [NUM_CH];
  logic [WORD_W-1:0] src_a    [NUM_CH];
  logic [WORD_W-1:0] id_a     [NUM_CH];
  logic [WORD_W-1:0] cmd_a    [NUM_CH];
  logic [WORD_W-1:0] branch_a [NUM_CH];

  logic [CH_W-1:0]   cur_ch;
  logic              clr_src, clr_bra, ld_en;
  logic [1:0]        ld_idx;
  logic              cur_en;
  logic [WORD_W-1:0] cur_branch, cur_next, cur_src;
  logic [WORD_W-1:0] sel_cmd;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic hit_sw, hit_hw;
    assign hit_sw = reg_wr && (reg_ch == CH_W'(gi));
    assign hit_hw = (cur_ch == CH_W'(gi));

    ldf_chan_regs u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_wr_next   (hit_sw && reg_sel == FLD_NEXT),
      .sw_wr_branch (hit_sw && reg_sel == FLD_BRANCH),
      .sw_data      (reg_wdata),
      .hw_clr_src   (hit_hw && clr_src),
      .hw_clr_bra   (hit_hw && clr_bra),
      .hw_ld_en     (hit_hw && ld_en),
      .hw_ld_idx    (ld_idx),
      .hw_ld_data   (rd_data),
      .next_o       (next_a[gi]),
      .src_o        (src_a[gi]),
      .id_o         (id_a[gi]),
      .cmd_o        (cmd_a[gi]),
      .branch_o     (branch_a[gi])
    );
  end

  always_comb begin
    cur_en     = 1'b0;
    cur_branch = '0;
    cur_next   = '0;
    cur_src    = '0;
    sel_cmd    = '0;
    reg_rdata  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cur_ch == CH_W'(i)) begin
        cur_en     = ch_en[i];
        cur_branch = branch_a[i];
        cur_next   = next_a[i];
        cur_src    = src_a[i];
      end
      if (reg_ch == CH_W'(i)) begin
        sel_cmd = cmd_a[i];
        unique case (reg_sel)
          FLD_NEXT:   reg_rdata = next_a[i];
          FLD_SRC:    reg_rdata = src_a[i];
          FLD_ID:     reg_rdata = id_a[i];
          FLD_CMD:    reg_rdata = cmd_a[i];
          FLD_BRANCH: reg_rdata = branch_a[i];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end

  assign sel_len_words = sel_cmd[20:2];
  assign sel_eof_ie    = sel_cmd[CMD_EOF_BIT];
  assign sel_sof_ie    = sel_cmd[CMD_SOF_BIT];
  assign sel_pal       = sel_cmd[CMD_PAL_BIT];

  ldf_seq #(
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .cur_en       (cur_en),
    .cur_branch   (cur_branch),
    .cur_next     (cur_next),
    .cur_src      (cur_src),
    .rd_valid     (rd_valid),
    .cur_ch       (cur_ch),
    .clr_src      (clr_src),
    .clr_bra      (clr_bra),
    .ld_en        (ld_en),
    .ld_idx       (ld_idx),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .busy         (busy),
    .frame_done   (frame_done),
    .ev_branch    (ev_branch),
    .ev_branch_ch (ev_branch_ch),
    .ev_buserr    (ev_buserr),
    .ev_buserr_ch (ev_buserr_ch)
  );

  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
endmodule

// File: tb/test_ldf_fetch.sv
module test_ldf_fetch;
  import ldf_pkg::*;

  localparam int NCH = 3;
  localparam int CHW = 2;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SIZE = 32'h0000_0100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, frame_start, rd_req, rd_valid, reg_wr;
  logic [NCH-1:0]  ch_en;
  logic [31:0]     rd_addr, rd_data, reg_wdata, reg_rdata;
  logic [CHW-1:0]  reg_ch, ev_branch_ch, ev_buserr_ch;
  logic [2:0]      reg_sel;
  logic [18:0]     sel_len_words;
  logic            sel_eof_ie, sel_sof_ie, sel_pal, busy, frame_done, ev_branch, ev_buserr;

  ldf_fetch #(.NUM_CH(NCH), .WIN_BASE(BASE), .WIN_SIZE(SIZE)) i_ldf_fetch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_en(ch_en),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sel_len_words(sel_len_words), .sel_eof_ie(sel_eof_ie),
    .sel_sof_ie(sel_sof_ie), .sel_pal(sel_pal), .busy(busy), .frame_done(frame_done),
    .ev_branch(ev_branch), .ev_branch_ch(ev_branch_ch), .ev_buserr(ev_buserr),
    .ev_buserr_ch(ev_buserr_ch)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // memory model
  logic [31:0] mem [64];
  int pend = 0, lat = 0, n_reads = 0, overlap = 0, bad_addr = 0;
  logic [5:0] ridx = '0;
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
  end
  always @(negedge clk) begin
    int was_pend;
    was_pend = pend;
    rd_valid <= 1'b0;
    if (pend != 0) begin
      if (lat == 0) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[ridx];
        pend = 0;
      end else begin
        lat = lat - 1;
      end
    end
    if (rd_req === 1'b1) begin
      n_reads++;
      if (was_pend != 0) overlap++;
      if (!(rd_addr >= BASE && rd_addr + 32'd4 <= BASE + SIZE)) bad_addr++;
      pend = 1;
      lat  = int'(rd_addr[3:2]) % 3;
      ridx = 6'((rd_addr - BASE) >> 2);
    end
  end

  // event monitor
  int br_ev [NCH];
  int be_ev [NCH];
  int last_br = -1, last_be = -1, order_bad = 0, n_done = 0;
  always @(negedge clk) begin
    if (ev_branch === 1'b1) begin
      if (int'(ev_branch_ch) < NCH) br_ev[ev_branch_ch]++;
      if (int'(ev_branch_ch) <= last_br) order_bad++;
      last_br = int'(ev_branch_ch);
    end
    if (ev_buserr === 1'b1) begin
      if (int'(ev_buserr_ch) < NCH) be_ev[ev_buserr_ch]++;
      if (int'(ev_buserr_ch) <= last_be) order_bad++;
      last_be = int'(ev_buserr_ch);
    end
    if (frame_done === 1'b1) n_done++;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  // reference model
  logic [31:0] m_next [NCH];
  logic [31:0] m_src  [NCH];
  logic [31:0] m_id   [NCH];
  logic [31:0] m_cmd  [NCH];
  logic [31:0] m_br   [NCH];
  int exp_br [NCH];
  int exp_be [NCH];

  function automatic bit in_desc(input logic [31:0] a);
    return ({1'b0, a} >= {1'b0, BASE}) && ({1'b0, a} + 33'd16 <= {1'b0, BASE} + {1'b0, SIZE});
  endfunction

  function automatic bit in_src(input logic [31:0] a);
    return (a != 32'd0) && ({1'b0, a} >= {1'b0, BASE}) && ({1'b0, a} <= {1'b0, BASE} + {1'b0, SIZE});
  endfunction

  task automatic reg_write(input int ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ch = CHW'(ch); reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int ch, input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_ch = CHW'(ch); reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic prepare(input int f, input int s, input logic [NCH-1:0] mask, output int er);
    logic [31:0] rb;
    er = 0;
    for (int c = 0; c < NCH; c++) begin
      int sc;
      logic [31:0] nslot, bslot, nxt, br, srcv, tgt;
      sc    = (s + 3 * c) % 8;
      nslot = BASE + 32'(32 * c);
      bslot = nslot + 32'd16;
      nxt   = nslot;
      br    = 32'd0;
      srcv  = f[0] ? BASE : BASE + SIZE;
      case (sc)
        1: br = bslot | 32'd1;
        2: br = bslot | 32'd3;
        3: nxt = f[0] ? BASE + SIZE : BASE - 32'd16;
        4: srcv = 32'd0;
        5: srcv = f[0] ? BASE + SIZE + 32'd4 : BASE - 32'd4;
        6: nxt = BASE + 32'h0F0;
        7: br = bslot | 32'd2;
        default: ;
      endcase
      tgt = br[0] ? bslot : nxt;
      if (in_desc(tgt)) begin
        int i0;
        i0 = int'((tgt - BASE) >> 2);
        mem[i0]     = 32'hA000_0000 | 32'(f << 8) | 32'(c << 4) | 32'd5;
        mem[i0 + 1] = srcv;
        mem[i0 + 2] = 32'h1D00_0000 | 32'(f << 4) | 32'(c);
        mem[i0 + 3] = 32'(f) * 32'h0011_2233 ^ 32'(c) * 32'h0640_0C04;
      end
      reg_write(c, FLD_NEXT, nxt | 32'hB);
      reg_write(c, FLD_BRANCH, br | 32'hC);
      m_next[c] = nxt;
      m_br[c]   = br;
      reg_read(c, FLD_NEXT, rb);
      check($sformatf("R2 ch%0d next write mask", c), rb, nxt);
    end
    for (int c = 0; c < NCH; c++) begin
      exp_br[c] = 0;
      exp_be[c] = 0;
      if (!mask[c]) begin
        m_src[c] = 32'd0;
      end else begin
        logic [31:0] a;
        a = m_br[c][0] ? {m_br[c][31:4], 4'd0} : m_next[c];
        if (m_br[c][0]) begin
          exp_br[c] = m_br[c][1] ? 1 : 0;
          m_br[c][0] = 1'b0;
        end
        if (in_desc(a)) begin
          int i0;
          i0 = int'((a - BASE) >> 2);
          m_next[c] = mem[i0];
          m_src[c]  = mem[i0 + 1];
          m_id[c]   = mem[i0 + 2];
          m_cmd[c]  = mem[i0 + 3];
          er += 4;
        end else begin
          m_src[c] = 32'd0;
        end
        exp_be[c] = in_src(m_src[c]) ? 0 : 1;
      end
    end
  endtask

  task automatic start_pulse(input logic [NCH-1:0] mask);
    @(negedge clk);
    ch_en = mask;
    for (int c = 0; c < NCH; c++) begin
      br_ev[c] = 0;
      be_ev[c] = 0;
    end
    last_br = -1; last_be = -1; order_bad = 0; n_reads = 0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic check_frame(input int f, input logic [NCH-1:0] mask, input int er);
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      string tg;
      tg = mask[c] ? "R6" : "R3";
      reg_read(c, FLD_NEXT, v);   check($sformatf("%s f%0d ch%0d next", tg, f, c), v, m_next[c]);
      reg_read(c, FLD_SRC, v);    check($sformatf("R7 f%0d ch%0d source", f, c), v, m_src[c]);
      reg_read(c, FLD_ID, v);     check($sformatf("%s f%0d ch%0d id", tg, f, c), v, m_id[c]);
      reg_read(c, FLD_CMD, v);    check($sformatf("%s f%0d ch%0d cmd", tg, f, c), v, m_cmd[c]);
      reg_read(c, FLD_BRANCH, v); check($sformatf("R4 f%0d ch%0d branch", f, c), v, m_br[c]);
      check($sformatf("R5 f%0d ch%0d branch events", f, c), 32'(br_ev[c]), 32'(exp_br[c]));
      check($sformatf("R8 f%0d ch%0d bus errors", f, c), 32'(be_ev[c]), 32'(exp_be[c]));
      #1;
      check($sformatf("R10 f%0d ch%0d cmd decode", f, c),
            {10'd0, sel_pal, sel_sof_ie, sel_eof_ie, sel_len_words},
            {10'd0, m_cmd[c][26], m_cmd[c][22], m_cmd[c][21], m_cmd[c][20:2]});
    end
    check($sformatf("R7 f%0d read count", f), 32'(n_reads), 32'(er));
    check($sformatf("R7 f%0d out-of-window reads", f), 32'(bad_addr), 32'd0);
    check($sformatf("R9 f%0d overlapping reads", f), 32'(overlap), 32'd0);
    check($sformatf("R3 f%0d channel order", f), 32'(order_bad), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int er, done0, fr;
    rst_n = 1'b0; frame_start = 1'b0; ch_en = '0; reg_wr = 1'b0;
    reg_ch = '0; reg_sel = '0; reg_wdata = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    for (int c = 0; c < NCH; c++) begin
      m_next[c] = 0; m_src[c] = 0; m_id[c] = 0; m_cmd[c] = 0; m_br[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 5; s++) begin
        reg_read(c, 3'(s), v);
        check($sformatf("R1 ch%0d field %0d after reset", c, s), v, 32'd0);
      end
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 no request after reset", {31'd0, rd_req}, 32'd0);

    // write masks and read-only fields
    reg_write(0, FLD_NEXT, 32'hFFFF_FFFF);
    reg_read(0, FLD_NEXT, v);   check("R2 next mask all ones", v, 32'hFFFF_FFF0);
    reg_write(0, FLD_BRANCH, 32'hFFFF_FFFF);
    reg_read(0, FLD_BRANCH, v); check("R2 branch mask all ones", v, 32'hFFFF_FFF3);
    reg_write(0, FLD_BRANCH, 32'd0);
    for (int s = 1; s < 4; s++) begin
      reg_write(1, 3'(s), 32'hFFFF_FFFF);
      reg_read(1, 3'(s), v);
      check($sformatf("R2 field %0d not writable", s), v, 32'd0);
    end
    reg_write(3, FLD_NEXT, 32'h1234_5670);
    reg_read(3, FLD_NEXT, v);   check("R2 out-of-range channel reads zero", v, 32'd0);
    reg_read(0, FLD_NEXT, v);   check("R2 out-of-range write ignored", v, 32'hFFFF_FFF0);

    // sweep
    fr = 0;
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 8; s++) begin
        prepare(fr, s, NCH'(m), er);
        done0 = n_done;
        start_pulse(NCH'(m));
        while (n_done == done0) @(negedge clk);
        repeat (2) @(negedge clk);
        check($sformatf("R11 f%0d idle after done", fr), {31'd0, busy}, 32'd0);
        check_frame(fr, NCH'(m), er);
        fr++;
      end

    // second start while busy is ignored
    prepare(fr, 0, 3'b111, er);
    done0 = n_done;
    start_pulse(3'b111);
    repeat (3) @(negedge clk);
    check("R11 busy during pass", {31'd0, busy}, 32'd1);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    while (n_done == done0) @(negedge clk);
    repeat (100) @(negedge clk);
    check("R11 single done for double start", 32'(n_done - done0), 32'd1);
    check("R11 no second pass reads", 32'(n_reads), 32'(er));
    check("R11 idle at end", {31'd0, busy}, 32'd0);
    check_frame(fr, 3'b111, er);

    summary();
    $finish;
  end
endmodule